// File: doc/BRIEF.md
# Byte-Windowed Memory Access Port

This block lets an 8-bit host I/O bus reach a 32-bit wide internal memory through six byte registers. Two of them hold a word address and an access-mode field. The other four are data lanes that the host reads or writes one byte at a time. The host programs an address once and then moves bytes through the data lanes. The mode decides whether each lane touches memory directly, or whether bytes are collected in a 32-bit staging word.

In the long modes the staging word gives the side effects. A read of lane 0 fetches the whole memory word into the stage. A write of lane 3 commits the stage, with the written byte as its top lane, to memory. In auto-increment mode the word address also advances after lane 3 is read or written, so a sequence of consecutive words needs only one address write. The half-word mode works in the same way on each 16-bit half. Byte mode passes every lane access straight through to memory.

The host sees its read data one clock after the read strobe. The memory model is synchronous on write and is indexed by the low bits of the word address.

Top module: `win_mem_port`

## Requirements
- R1: After reset the word address, the mode and `host_rdata` are all zero.
- R2: Offset 0 holds word-address bits [7:2] in data bits [7:2] and the mode in bits [1:0] (0 byte, 1 half-word, 2 long, 3 long auto-increment). It reads back exactly as written.
- R3: Offset 1 holds word-address bits [14:8] in its low seven bits. Bit 7 is dropped on write and reads as 0.
- R4: In byte mode, data lane n (offsets 2 to 5 map to lanes 0 to 3) reads or writes memory byte n of the addressed word directly. A write changes only that byte lane.
- R5: In modes 2 and 3, a read of lane 0 loads the addressed word into the stage and returns its byte 0. Reads of lanes 1 to 3 return staged bytes without fetching memory.
- R6: In modes 2 and 3, writes of lanes 0 to 2 update only the stage. A write of lane 3 stores the stage, with the written byte as byte 3, as one full word.
- R7: In mode 3 the word address advances by one after any lane-3 read or write. Modes 0, 1 and 2 never change the address.
- R8: The advance wraps from the top of the 15-bit byte address space to word 0.
- R9: In mode 1, reads of lane 0 or 2 fetch the word. Writes of lanes 0 and 2 only stage. A write of lane 1 commits bytes 0 and 1, and a write of lane 3 commits bytes 2 and 3.
- R10: Offsets 6 and 7 read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe, one cycle per byte |
| host_rd | input | 1 | Read strobe; ignored while host_wr is high |
| host_ofs | input | 3 | Register offset within the window |
| host_wdata | input | 8 | Write byte |
| host_rdata | output | 8 | Read byte, valid the cycle after host_rd |

## Verification
On every cycle the embedded assertions check several properties. The address advances by exactly one word after a lane-3 access in auto-increment mode, and it stays put otherwise. A lane-3 long write stores the staged bytes with the new top byte. Lower-lane long writes leave memory unchanged. A lane-0 long read returns the memory byte and captures the word. Offset 1 never returns bit 7 set. Some behaviour can only be shown by the bench's scripted sequences: wrap at the top of the address space, byte-lane isolation in byte mode, stale staged data being returned instead of fresh memory, half-word commits, and the inert unused offsets.

// File: rtl/win_mem_port.sv
module win_mem_port #(
  parameter int MEM_WORDS = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [2:0] host_ofs,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata
);
  localparam int ADDR_BITS = 15;
  localparam int WADDR_W   = ADDR_BITS - 2;
  localparam int IDX_W     = $clog2(MEM_WORDS);

  logic [31:0]        mem [MEM_WORDS];
  logic [WADDR_W-1:0] waddr;
  logic [1:0]         mode;
  logic [31:0]        stage;
  logic [7:0]         rdata_q;

  logic [IDX_W-1:0] idx;
  logic [31:0]      cur;
  logic [1:0]       lane;
  logic             do_wr, do_rd, is_data;
  logic             m_byte, m_half, m_long, m_inc;
  logic             fetch, commit_long, commit_lo, commit_hi, byte_wr, advance;
  logic [3:0]       be;
  logic [31:0]      mem_wd;
  logic [7:0]       rd_next;

  assign idx     = waddr[IDX_W-1:0];
  assign cur     = mem[idx];
  assign lane    = host_ofs[1:0] + 2'd2;
  assign do_wr   = host_wr;
  assign do_rd   = host_rd & ~host_wr;
  assign is_data = (host_ofs >= 3'd2) && (host_ofs <= 3'd5);
  assign m_byte  = (mode == 2'd0);
  assign m_half  = (mode == 2'd1);
  assign m_long  = mode[1];
  assign m_inc   = (mode == 2'd3);

  assign fetch       = do_rd & is_data & ((m_long & (lane == 2'd0)) | (m_half & ~lane[0]));
  assign commit_long = do_wr & is_data & m_long & (lane == 2'd3);
  assign commit_lo   = do_wr & is_data & m_half & (lane == 2'd1);
  assign commit_hi   = do_wr & is_data & m_half & (lane == 2'd3);
  assign byte_wr     = do_wr & is_data & m_byte;
  assign advance     = m_inc & is_data & (lane == 2'd3) & (do_wr | do_rd);

  always_comb begin
    be     = 4'b0000;
    mem_wd = {host_wdata, stage[23:16], host_wdata, stage[7:0]};
    if (byte_wr) begin
      be     = 4'b0001 << lane;
      mem_wd = {4{host_wdata}};
    end else if (commit_long) begin
      be     = 4'b1111;
      mem_wd = {host_wdata, stage[23:0]};
    end else if (commit_lo) begin
      be     = 4'b0011;
    end else if (commit_hi) begin
      be     = 4'b1100;
    end
  end

  for (genvar l = 0; l < 4; l++) begin : g_lane
    always_ff @(posedge clk)
      if (be[l]) mem[idx][8*l +: 8] <= mem_wd[8*l +: 8];
  end

  always_comb begin
    rd_next = 8'h00;
    case (host_ofs)
      3'd0: rd_next = {waddr[5:0], mode};
      3'd1: rd_next = {1'b0, waddr[WADDR_W-1:6]};
      3'd2, 3'd3, 3'd4, 3'd5:
        rd_next = (m_byte | fetch) ? cur[8*lane +: 8] : stage[8*lane +: 8];
      default: rd_next = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      waddr   <= '0;
      mode    <= 2'd0;
      stage   <= '0;
      rdata_q <= 8'h00;
    end else begin
      if (do_rd) rdata_q <= rd_next;
      if (fetch) stage <= cur;
      else if (do_wr & is_data & ~m_byte) stage[8*lane +: 8] <= host_wdata;
      if (do_wr && host_ofs == 3'd0) begin
        waddr[5:0] <= host_wdata[7:2];
        mode       <= host_wdata[1:0];
      end else if (do_wr && host_ofs == 3'd1) begin
        waddr[WADDR_W-1:6] <= host_wdata[6:0];
      end else if (advance) begin
        waddr <= waddr + 1'b1;
      end
    end
  end

  assign host_rdata = rdata_q;

  AST_AUTO_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (m_inc && is_data && lane == 2'd3 && (host_wr || host_rd)) |=> waddr == $past(waddr) + 1'b1); // R7

  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(host_wr && host_ofs <= 3'd1) && !(mode == 2'd3 && is_data && lane == 2'd3 && (host_wr || host_rd)))
    |=> $stable(waddr)); // R7

  AST_LONG_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && mode[1] && host_ofs == 3'd5) |=> mem[$past(idx)] == {$past(host_wdata), $past(stage[23:0])}); // R6

  AST_STAGE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && mode[1] && host_ofs >= 3'd2 && host_ofs <= 3'd4) |=> mem[$past(idx)] == $past(cur)); // R6

  AST_LONG_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && mode[1] && host_ofs == 3'd2)
    |=> (host_rdata == $past(cur[7:0])) && (stage == $past(cur))); // R5

  AST_HI_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !host_wr && host_ofs == 3'd1) |=> host_rdata[7] == 1'b0); // R3
endmodule

// File: tb/sim_win_mem_port.sv
`timescale 1ns/1ps
module sim_win_mem_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_wr = 1'b0;
  logic       host_rd = 1'b0;
  logic [2:0] host_ofs = 3'd0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;

  int checks = 0;
  int errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;

  always #2.5 clk = ~clk;

  win_mem_port u0 (.clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
                   .host_ofs(host_ofs), .host_wdata(host_wdata), .host_rdata(host_rdata));

  task automatic wr(input logic [2:0] o, input logic [7:0] d);
    host_ofs = o; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] o, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    host_ofs = o; host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
  endtask

  always @(posedge clk) rd_seen <= host_rd & ~host_wr & rst_n;

  always @(negedge clk) begin
    if (rd_seen) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (host_rdata !== e) begin
        errors++;
        $display("FAIL %s: got %02h expected %02h", t, host_rdata, e);
      end
    end
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (host_rdata !== 8'h00) begin
      errors++;
      $display("FAIL R1: got %02h expected 00", host_rdata);
    end
    rd(3'd0, 8'h00, "R1 addr0 reset");
    rd(3'd1, 8'h00, "R1 addr1 reset");

    wr(3'd0, 8'hA7); rd(3'd0, 8'hA7, "R2 addr0 readback");
    wr(3'd1, 8'hFF); rd(3'd1, 8'h7F, "R3 bit7 dropped");

    // R8: top word, long auto-increment
    wr(3'd1, 8'h7F); wr(3'd0, 8'hFF);
    wr(3'd2, 8'h11); wr(3'd3, 8'h22); wr(3'd4, 8'h33); wr(3'd5, 8'h44);
    rd(3'd0, 8'h03, "R8 wrap low");
    rd(3'd1, 8'h00, "R8 wrap high");
    wr(3'd1, 8'h7F); wr(3'd0, 8'hFF);
    rd(3'd2, 8'h11, "R5 fetch b0");
    rd(3'd3, 8'h22, "R5 staged b1");
    rd(3'd4, 8'h33, "R5 staged b2");
    rd(3'd5, 8'h44, "R5 staged b3");
    rd(3'd0, 8'h03, "R8 wrap on read");

    // R4: byte mode at word 4
    wr(3'd1, 8'h00); wr(3'd0, 8'h10);
    wr(3'd2, 8'h01); wr(3'd3, 8'h02); wr(3'd4, 8'h03); wr(3'd5, 8'h04);
    rd(3'd4, 8'h03, "R4 byte lane2");
    rd(3'd3, 8'h02, "R4 byte lane1");

    // R6: long without increment
    wr(3'd0, 8'h12);
    wr(3'd2, 8'hAA); wr(3'd3, 8'hBB); wr(3'd4, 8'hCC);
    wr(3'd0, 8'h10);
    rd(3'd2, 8'h01, "R6 stage only b0");
    rd(3'd4, 8'h03, "R6 stage only b2");
    wr(3'd0, 8'h12);
    wr(3'd5, 8'hDD);
    rd(3'd0, 8'h12, "R7 no advance mode2");
    wr(3'd0, 8'h10);
    rd(3'd2, 8'hAA, "R6 commit b0");
    rd(3'd5, 8'hDD, "R6 commit b3");

    // R5: staged reads do not refetch
    wr(3'd0, 8'h12);
    rd(3'd2, 8'hAA, "R5 fetch");
    wr(3'd0, 8'h10); wr(3'd3, 8'h55);
    wr(3'd0, 8'h12);
    rd(3'd3, 8'hBB, "R5 stale stage b1");
    rd(3'd5, 8'hDD, "R5 stale stage b3");

    // R7: auto-increment bursts at word 8
    wr(3'd0, 8'h23);
    wr(3'd2, 8'h0A); wr(3'd3, 8'h0B); wr(3'd4, 8'h0C); wr(3'd5, 8'h0D);
    wr(3'd2, 8'h1A); wr(3'd3, 8'h1B); wr(3'd4, 8'h1C); wr(3'd5, 8'h1D);
    rd(3'd0, 8'h2B, "R7 two advances");
    wr(3'd0, 8'h23);
    rd(3'd2, 8'h0A, "R7 burst b0");
    rd(3'd3, 8'h0B, "R7 burst b1");
    rd(3'd4, 8'h0C, "R7 burst b2");
    rd(3'd5, 8'h0D, "R7 burst b3");
    rd(3'd2, 8'h1A, "R7 next word");
    rd(3'd0, 8'h27, "R7 advance on b3 only");

    // R9: half-word mode at word 12
    wr(3'd0, 8'h30);
    wr(3'd2, 8'h10); wr(3'd3, 8'h20); wr(3'd4, 8'h30); wr(3'd5, 8'h40);
    wr(3'd0, 8'h31);
    wr(3'd2, 8'hE0); wr(3'd3, 8'hE1);
    wr(3'd0, 8'h30);
    rd(3'd2, 8'hE0, "R9 low commit b0");
    rd(3'd3, 8'hE1, "R9 low commit b1");
    rd(3'd4, 8'h30, "R9 high untouched");
    wr(3'd0, 8'h31);
    wr(3'd4, 8'hF2); wr(3'd5, 8'hF3);
    wr(3'd0, 8'h30);
    rd(3'd5, 8'hF3, "R9 high commit b3");
    rd(3'd4, 8'hF2, "R9 high commit b2");
    wr(3'd0, 8'h31);
    rd(3'd4, 8'hF2, "R9 fetch b2");
    rd(3'd5, 8'hF3, "R9 staged b3");
    rd(3'd0, 8'h31, "R9 no advance");

    // R10: unused offsets
    wr(3'd6, 8'h99); wr(3'd7, 8'h77);
    rd(3'd6, 8'h00, "R10 ofs6");
    rd(3'd7, 8'h00, "R10 ofs7");
    rd(3'd0, 8'h31, "R10 addr intact");
    wr(3'd0, 8'h30);
    rd(3'd2, 8'hE0, "R10 memory intact");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule